// File: doc/BRIEF.md
# SPI Interrupt Status and Mask Unit

This unit keeps the interrupt state of a FIFO-based SPI controller. It watches the occupancy of the transmit and receive FIFOs and a one-cycle mode-fault indication. It records four event kinds in a seven-bit status word and combines that word with an enable mask to drive one level-sensitive interrupt line. The FIFOs and the serial shifter live elsewhere. This block only receives their fill counts.

Software reaches the unit through a small register port with a write strobe and a read strobe. Status bits are cleared by writing ones to them. The mask cannot be written directly. A set-only port turns mask bits on and a clear-only port turns them off, and the mask itself can only be read. A programmable low-water threshold decides when the transmit FIFO counts as running dry.

The three FIFO-driven bits are level sources. A bit is set in every cycle in which its condition holds, so a clear only sticks once the condition has gone. The mode-fault bit is a small two-state machine. `MF_CLEAR` moves to `MF_HELD` when a fault pulse arrives. `MF_HELD` returns to `MF_CLEAR` when software writes a one to that bit and no new pulse arrives in the same cycle. In every other case the state holds.

Register addresses: 0 status (read, write-one-to-clear), 1 mask set (write), 2 mask clear (write), 3 mask (read), 4 low-water threshold (read/write). Status bit positions are shared by all mask views: bit 1 mode fault, bit 2 transmit below threshold, bit 3 transmit full, bit 4 receive not empty. Bits 0, 5 and 6 are reserved.

Top module: `spi_irq_unit`

## Requirements
- R1: After reset the status word reads 0, the mask reads 0, the threshold reads 1 and `irq` is low.
- R2: A high `modf_evt` sets status bit 1 at the next clock edge. The bit then stays set until a write of 1 to bit 1 at address 0. If a pulse arrives in the same cycle as that clear, the bit stays set.
- R3: Status bit 2 is set at each edge where `tx_level` is strictly below the threshold. Equality does not set it. A clear while the condition still holds has no lasting effect.
- R4: Status bit 3 is set at each edge where `tx_level` is at least FIFO_DEPTH (128).
- R5: Status bit 4 is set at each edge where `rx_level` is non-zero, and it stays set after clears for as long as any entry remains.
- R6: Zero bits written to address 0 leave status unchanged. Reserved status bits 0, 5 and 6 always read 0.
- R7: A write to address 1 sets the mask bits written as 1. A write to address 2 clears them. Zero bits change nothing, and writes to address 3 leave the mask unchanged.
- R8: `irq` is high exactly when some status bit and its mask bit are both set.
- R9: A write to address 4 loads the threshold, which reads back at address 4.
- R10: `reg_rdata` takes the addressed value at the edge that samples `reg_rd` and holds it otherwise. Addresses 1, 2, 5, 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| tx_level | input | 8 | Transmit FIFO occupancy, 0 to FIFO_DEPTH |
| rx_level | input | 8 | Receive FIFO occupancy, 0 to FIFO_DEPTH |
| modf_evt | input | 1 | Mode-fault pulse |
| irq | output | 1 | Level interrupt |

## Verification
Every status, mask and threshold change takes effect at the first clock edge that samples its cause. `irq` follows those registers with no further delay, so the bench checks it at the falling edge right after that rising edge. A read returns the state as it stood before the sampling edge and is compared one half cycle after that edge. A directed check of a status change therefore issues its read one full cycle after the cause, for example a threshold write followed first by a threshold read and only then by a status read. The bench drives inputs on falling edges and updates its reference model at each rising edge from those stable inputs. Every comparison happens at the next falling edge.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
    localparam int STAT_W = 7;
    localparam int BIT_MODF = 1;
    localparam int BIT_TXLOW = 2;
    localparam int BIT_TXFULL = 3;
    localparam int BIT_RXNE = 4;

    typedef enum logic [2:0] {
        ADR_STATUS = 3'd0,
        ADR_MSET   = 3'd1,
        ADR_MCLR   = 3'd2,
        ADR_MASK   = 3'd3,
        ADR_WMARK  = 3'd4
    } reg_addr_e;

    typedef enum logic {
        MF_CLEAR = 1'b0,
        MF_HELD  = 1'b1
    } modf_state_e;
endpackage

// File: rtl/spi_irq_sources.sv
module spi_irq_sources #(
    parameter int FIFO_DEPTH = 128,
    parameter int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] thr,
    output logic             tx_low,
    output logic             tx_full,
    output logic             rx_nonempty
);
    localparam logic [LVL_W-1:0] FULL_MARK = LVL_W'(FIFO_DEPTH);

    always_comb begin
        tx_low      = (tx_level < thr);
        tx_full     = (tx_level >= FULL_MARK);
        rx_nonempty = (rx_level != '0);
    end
endmodule

// File: rtl/spi_irq_level_bit.sv
module spi_irq_level_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic clr,
    output logic q
);
    // a condition seen in this cycle wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= (q & ~clr) | cond;
    end
endmodule

// File: rtl/spi_irq_modf.sv
module spi_irq_modf
    import spi_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic held
);
    modf_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MF_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MF_CLEAR: if (evt) state_d = MF_HELD;
            MF_HELD:  if (clr && !evt) state_d = MF_CLEAR;
            default:  state_d = MF_CLEAR;
        endcase
    end

    always_comb begin
        held = (state_q == MF_HELD);
    end
endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] bits,
    output logic [W-1:0] mask_q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  mask_q[i] <= 1'b0;
            else if (set_en && bits[i])  mask_q[i] <= 1'b1;
            else if (clr_en && bits[i])  mask_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
    import spi_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 128,
    parameter int DATA_W = 8,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              modf_evt,
    output logic              irq
);
    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] mask_q;
    logic [LVL_W-1:0]  thr_q;
    logic [DATA_W-1:0] rdata_d;
    logic wr_status, wr_mset, wr_mclr, wr_wmark;
    logic tx_low, tx_full, rx_nonempty;

    always_comb begin
        wr_status = reg_wr && (reg_addr_e'(reg_addr) == ADR_STATUS);
        wr_mset   = reg_wr && (reg_addr_e'(reg_addr) == ADR_MSET);
        wr_mclr   = reg_wr && (reg_addr_e'(reg_addr) == ADR_MCLR);
        wr_wmark  = reg_wr && (reg_addr_e'(reg_addr) == ADR_WMARK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        thr_q <= LVL_W'(1);
        else if (wr_wmark) thr_q <= reg_wdata[LVL_W-1:0];
    end

    spi_irq_sources #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_src (
        .tx_level   (tx_level),
        .rx_level   (rx_level),
        .thr        (thr_q),
        .tx_low     (tx_low),
        .tx_full    (tx_full),
        .rx_nonempty(rx_nonempty)
    );

    for (genvar b = 0; b < STAT_W; b++) begin : g_stat
        if (b == BIT_MODF) begin : g_modf
            spi_irq_modf u_modf (
                .clk  (clk),
                .rst_n(rst_n),
                .evt  (modf_evt),
                .clr  (wr_status & reg_wdata[b]),
                .held (status_q[b])
            );
        end else if (b == BIT_TXLOW) begin : g_txlow
            spi_irq_level_bit u_lvl (
                .clk(clk), .rst_n(rst_n), .cond(tx_low),
                .clr(wr_status & reg_wdata[b]), .q(status_q[b])
            );
        end else if (b == BIT_TXFULL) begin : g_txfull
            spi_irq_level_bit u_lvl (
                .clk(clk), .rst_n(rst_n), .cond(tx_full),
                .clr(wr_status & reg_wdata[b]), .q(status_q[b])
            );
        end else if (b == BIT_RXNE) begin : g_rxne
            spi_irq_level_bit u_lvl (
                .clk(clk), .rst_n(rst_n), .cond(rx_nonempty),
                .clr(wr_status & reg_wdata[b]), .q(status_q[b])
            );
        end else begin : g_rsvd
            assign status_q[b] = 1'b0;
        end
    end

    spi_irq_mask #(.W(STAT_W)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .set_en(wr_mset),
        .clr_en(wr_mclr),
        .bits  (reg_wdata[STAT_W-1:0]),
        .mask_q(mask_q)
    );

    always_comb begin
        rdata_d = '0;
        unique case (reg_addr)
            ADR_STATUS: rdata_d = DATA_W'(status_q);
            ADR_MASK:   rdata_d = DATA_W'(mask_q);
            ADR_WMARK:  rdata_d = DATA_W'(thr_q);
            default:    rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rdata_d;
    end

    always_comb begin
        irq = |(status_q & mask_q);
    end
endmodule

// File: rtl/spi_irq_checker.sv
module spi_irq_checker #(
    parameter int FIFO_DEPTH = 128,
    parameter int DATA_W = 8,
    parameter int LVL_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [LVL_W-1:0]  tx_level,
    input logic [LVL_W-1:0]  rx_level,
    input logic              modf_evt,
    input logic              irq,
    input logic [6:0]        stat,
    input logic [6:0]        mask,
    input logic [LVL_W-1:0]  thr
);
    // R2
    modf_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        modf_evt |=> stat[1]);
    // R2
    modf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[1] && !(reg_wr && reg_addr == 3'd0 && reg_wdata[1])) |=> stat[1]);
    // R3
    tx_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level < thr) |=> stat[2]);
    // R4
    tx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level >= LVL_W'(FIFO_DEPTH)) |=> stat[3]);
    // R5
    rx_ne_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level != '0) |=> stat[4]);
    // R6
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[0] == 1'b0) && (stat[6:5] == 2'b00));
    // R7
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd1) |=> ((mask & $past(reg_wdata[6:0])) == $past(reg_wdata[6:0])));
    // R7
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd2) |=> ((mask & $past(reg_wdata[6:0])) == 7'd0));
    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 7'd0 || stat == 7'd0) |-> !irq);
endmodule

bind spi_irq_unit spi_irq_checker #(
    .FIFO_DEPTH(FIFO_DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .tx_level (tx_level),
    .rx_level (rx_level),
    .modf_evt (modf_evt),
    .irq      (irq),
    .stat     (status_q),
    .mask     (mask_q),
    .thr      (thr_q)
);

// File: tb/spi_irq_unit_test.sv
`timescale 1ns/1ps
module spi_irq_unit_test;
    localparam int DEPTH = 128;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr, reg_rd, modf_evt;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata, tx_level, rx_level;
    logic       irq;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [6:0] m_stat, m_mask;
    logic [7:0] m_thr, m_rdata;

    always #2 clk = ~clk;

    spi_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_level(tx_level), .rx_level(rx_level), .modf_evt(modf_evt), .irq(irq)
    );

    function automatic logic [7:0] model_read(logic [2:0] a, logic [6:0] s,
                                              logic [6:0] m, logic [7:0] t);
        case (a)
            3'd0: return {1'b0, s};
            3'd3: return {1'b0, m};
            3'd4: return t;
            default: return 8'd0;
        endcase
    endfunction

    function automatic logic [6:0] model_status(logic [6:0] s, logic [6:0] clr,
                                                logic [7:0] tx, logic [7:0] rx,
                                                logic [7:0] t, logic mf);
        logic [6:0] n;
        n = s & ~clr;
        n[1] = n[1] | mf;
        n[2] = n[2] | (tx < t);
        n[3] = n[3] | (tx >= 8'(DEPTH));
        n[4] = n[4] | (rx != 8'd0);
        n[0] = 1'b0;
        n[6:5] = 2'b00;
        return n;
    endfunction

    task automatic model_update();
        logic [6:0] clr;
        if (reg_rd) m_rdata = model_read(reg_addr, m_stat, m_mask, m_thr);
        clr = (reg_wr && reg_addr == 3'd0) ? reg_wdata[6:0] : 7'd0;
        m_stat = model_status(m_stat, clr, tx_level, rx_level, m_thr, modf_evt);
        if (reg_wr && reg_addr == 3'd1) m_mask = m_mask | reg_wdata[6:0];
        if (reg_wr && reg_addr == 3'd2) m_mask = m_mask & ~reg_wdata[6:0];
        if (reg_wr && reg_addr == 3'd4) m_thr = reg_wdata;
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(logic [2:0] a, string req, logic [7:0] exp);
        reg_rd = 1'b1; reg_addr = a;
        tick();
        reg_rd = 1'b0;
        check(req, {24'd0, reg_rdata}, {24'd0, exp});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5eed);
        rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 3'd0;
        reg_wdata = 8'd0; tx_level = 8'd5; rx_level = 8'd0; modf_evt = 1'b0;
        m_stat = 7'd0; m_mask = 7'd0; m_thr = 8'd1; m_rdata = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        check("R1 irq", {31'd0, irq}, 32'd0);
        rd_chk(3'd0, "R1 status", 8'h00);
        rd_chk(3'd3, "R1 mask", 8'h00);
        rd_chk(3'd4, "R1 threshold", 8'h01);

        // R2 fault latch, R8 masked
        modf_evt = 1'b1; tick(); modf_evt = 1'b0;
        rd_chk(3'd0, "R2 fault latched", 8'h02);
        check("R8 masked irq", {31'd0, irq}, 32'd0);

        // R7 set port, zeros and direct writes ignored
        wr(3'd1, 8'h02);
        rd_chk(3'd3, "R7 mask set", 8'h02);
        check("R8 irq on", {31'd0, irq}, 32'd1);
        wr(3'd1, 8'h00);
        rd_chk(3'd3, "R7 zero set no effect", 8'h02);
        wr(3'd3, 8'h7F);
        rd_chk(3'd3, "R7 mask read-only", 8'h02);

        // R6 zero writes to status
        wr(3'd0, 8'h00);
        rd_chk(3'd0, "R6 zero clear no effect", 8'h02);

        // R2 pulse during clear wins
        modf_evt = 1'b1; wr(3'd0, 8'h02); modf_evt = 1'b0;
        rd_chk(3'd0, "R2 pulse beats clear", 8'h02);
        wr(3'd0, 8'h02);
        rd_chk(3'd0, "R2 cleared", 8'h00);
        check("R8 irq off", {31'd0, irq}, 32'd0);

        // R3 low-water
        tx_level = 8'd0; tick();
        rd_chk(3'd0, "R3 below threshold", 8'h04);
        wr(3'd0, 8'h04);
        rd_chk(3'd0, "R3 reasserts", 8'h04);
        tx_level = 8'd5; wr(3'd0, 8'h04);
        rd_chk(3'd0, "R3 cleared", 8'h00);
        wr(3'd4, 8'd10);
        rd_chk(3'd4, "R9 threshold", 8'd10);
        rd_chk(3'd0, "R3 new threshold", 8'h04);
        tx_level = 8'd10; wr(3'd0, 8'h04);
        rd_chk(3'd0, "R3 equal not below", 8'h00);

        // R4 full
        tx_level = 8'd128; tick();
        rd_chk(3'd0, "R4 full", 8'h08);
        tx_level = 8'd12; wr(3'd0, 8'h08);
        rd_chk(3'd0, "R4 cleared", 8'h00);

        // R5 receive not empty persists
        rx_level = 8'd3; tick();
        wr(3'd0, 8'h10);
        rd_chk(3'd0, "R5 persists", 8'h10);
        rx_level = 8'd0; wr(3'd0, 8'h10);
        rd_chk(3'd0, "R5 drained", 8'h00);
        wr(3'd0, 8'h7F);
        rd_chk(3'd0, "R6 reserved zero", 8'h00);

        // R10 unmapped reads
        rd_chk(3'd7, "R10 unmapped 7", 8'h00);
        rd_chk(3'd1, "R10 unmapped 1", 8'h00);

        // R7 clear port
        wr(3'd2, 8'h02);
        rd_chk(3'd3, "R7 mask clear", 8'h00);
        wr(3'd1, 8'h1E);
        wr(3'd2, 8'h04);
        rd_chk(3'd3, "R7 partial clear", 8'h1A);

        // R8 receive interrupt
        rx_level = 8'd1; tick();
        check("R8 rx irq", {31'd0, irq}, 32'd1);
        rx_level = 8'd0; wr(3'd0, 8'h10);
        check("R8 rx irq cleared", {31'd0, irq}, 32'd0);

        // random mix, checked against the model (R2..R10)
        for (int i = 0; i < 400; i++) begin
            reg_wr    = ($urandom % 3) == 0;
            reg_rd    = ($urandom % 2) == 0;
            reg_addr  = 3'($urandom % 8);
            reg_wdata = 8'($urandom);
            if (reg_addr == 3'd4) reg_wdata = 8'($urandom % 20);
            tx_level  = 8'($urandom % 129);
            rx_level  = (($urandom % 3) == 0) ? 8'd0 : 8'($urandom % 129);
            modf_evt  = ($urandom % 8) == 0;
            tick();
            check("R8 random irq", {31'd0, irq}, {31'd0, |(m_stat & m_mask)});
            check("R10 random rdata", {24'd0, reg_rdata}, {24'd0, m_rdata});
        end
        reg_wr = 1'b0; reg_rd = 1'b0; modf_evt = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule